// File: doc/BRIEF.md
# Fractional Baud-Rate Generator

This block turns a fast reference clock into the timing pulses a UART needs. It produces an oversampling strobe, one pulse per divisor period. It also produces a square bit-rate clock derived from those strobes. The divisor has a 16-bit integer part `DIV` and a 4-bit fractional part `FRACT`, counted in sixteenths. The average strobe period is therefore `DIV + FRACT/16` reference cycles. The line rate in 1x mode is `f_ref / (16 * (DIV + FRACT/16))`. For example, a 28.23 MHz reference with DIV=9 and FRACT=5 gives about 189463 baud.

The fraction is realised by stretching individual periods by one reference cycle. The strobe spacing is therefore irregular, but the average is exact over every sixteen periods. A rate-mode input picks how many strobes make one bit. In 1x mode sixteen strobes make one bit. In 2x mode eight strobes make one bit, which doubles the line rate. In 4x mode four strobes make one bit, which quadruples it. The bit-rate clock follows the selected mode, so in 4x mode it runs at four times the programmed rate.

The period sequencer is a small state machine with three states:
- `PS_LOAD`: the first cycle after reset. Transition *start* moves to `PS_COUNT` and loads the first period.
- `PS_COUNT`: counts the integer part down.
  - Transition *reload* stays in `PS_COUNT` and ends the period when the count reaches zero and no stretch is owed.
  - Transition *extend* goes to `PS_STRETCH` when a stretch is owed.
- `PS_STRETCH`: lasts one cycle. Transition *finish* ends the period and returns to `PS_COUNT`.

Every period end, and the start, samples DIV, FRACT and the rate mode for the next period.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tick16_o` and `bclk_o` are both low.
- R2: The spacing between consecutive `tick16_o` pulses is either DIV or DIV+1 reference cycles. With FRACT=0 the spacing is exactly DIV.
- R3: Any sixteen consecutive periods with constant settings total exactly 16*DIV+FRACT reference cycles. For example, DIV=9 and FRACT=5 over 160 periods take 1490 cycles, which is about 189463 baud from a 28.23 MHz reference.
- R4: A DIV value of 0 behaves as DIV=1. With FRACT=0, `tick16_o` is then high in every cycle.
- R5: DIV, FRACT and the rate mode are sampled only at a period boundary. A change in mid-period leaves the current period's length unchanged.
- R6: `bclk_o` toggles only in cycles where a strobe is issued. It toggles once every 8 strobes for `rate_i`=2'b00, every 4 for 2'b01 and every 2 for 2'b10. The code 2'b11 behaves as 2'b00.
- R7: A fractional accumulator, cleared by reset, adds FRACT at each period start. The k-th period after reset is one cycle longer exactly when floor(k*FRACT/16) exceeds floor((k-1)*FRACT/16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | Integer divisor part |
| frac_i | input | 4 | Fractional divisor part in sixteenths |
| rate_i | input | 2 | Rate mode: 00 1x, 01 2x, 10 4x, 11 as 1x |
| tick16_o | output | 1 | One-cycle oversampling strobe per divisor period |
| bclk_o | output | 1 | Bit-rate clock output |

## Verification
Two events can fall on the same boundary: a one-cycle fractional stretch and a change of settings. The run provokes this with DIV=3 and FRACT=15, where nearly every period is stretched, and rewrites DIV and the rate mode just after a strobe. The stretched old period must complete at its old length before the new DIV takes effect. The second overlap is a bit-clock toggle on the same boundary that loads a new rate mode. It is judged by a behavioural model that tracks the expected strobe and bit-clock values on every clock.

// File: rtl/frbg_pkg.sv
package frbg_pkg;

    localparam int SCNT_W = 3;

    typedef enum logic [1:0] {
        RATE_X1  = 2'b00,
        RATE_X2  = 2'b01,
        RATE_X4  = 2'b10,
        RATE_ALT = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        PS_LOAD    = 2'b00,
        PS_COUNT   = 2'b01,
        PS_STRETCH = 2'b10
    } pstate_e;

    // strobes per half bit-clock period, minus one
    function automatic logic [SCNT_W-1:0] toggle_limit(input rate_e r);
        logic [SCNT_W-1:0] lim;
        case (r)
            RATE_X2: lim = SCNT_W'(3);
            RATE_X4: lim = SCNT_W'(1);
            default: lim = SCNT_W'(7);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/frbg_frac_acc.sv
module frbg_frac_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, frac_i};
        carry_o = sum[FRAC_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    AST_ZERO_FRAC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && frac_i == '0) |=> $stable(acc_q)); // R3

    AST_CARRY_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && carry_o) |=> (acc_q < $past(frac_i))); // R7

endmodule

// File: rtl/frbg_period_fsm.sv
module frbg_period_fsm
    import frbg_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             carry_i,
    output logic             load_o,
    output logic             end_o,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    pstate_e          state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] div_eff;
    logic             stretch_q, stretch_d;
    logic             tick_q;

    always_comb begin
        div_eff   = (div_i == '0) ? ONE : div_i;
        state_d   = state_q;
        cnt_d     = cnt_q;
        stretch_d = stretch_q;
        end_o     = 1'b0;
        load_o    = 1'b0;
        unique case (state_q)
            PS_LOAD: begin
                load_o = 1'b1;                       // start
            end
            PS_COUNT: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - ONE;
                end else if (stretch_q) begin
                    state_d = PS_STRETCH;            // extend
                end else begin
                    end_o  = 1'b1;                   // reload
                    load_o = 1'b1;
                end
            end
            PS_STRETCH: begin
                end_o  = 1'b1;                       // finish
                load_o = 1'b1;
            end
            default: state_d = PS_LOAD;
        endcase
        if (load_o) begin
            state_d   = PS_COUNT;
            cnt_d     = div_eff - ONE;
            stretch_d = carry_i;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= PS_LOAD;
            cnt_q     <= '0;
            stretch_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            stretch_q <= stretch_d;
        end
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= end_o;
        end
    end

    assign tick_o = tick_q;

    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_q && cnt_q != '0) |=> !tick_q); // R2

    AST_STRETCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PS_STRETCH) |=> (state_q == PS_COUNT)); // R2

    AST_STRETCH_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PS_STRETCH) |-> ($past(state_q) == PS_COUNT && $past(cnt_q) == '0)); // R7

    AST_UNIT_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_q && cnt_q == '0 && !stretch_q) |=> tick_q); // R4

endmodule

// File: rtl/frbg_bitclk.sv
module frbg_bitclk
    import frbg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic       end_i,
    input  logic [1:0] rate_i,
    output logic       bclk_o
);

    rate_e             rate_q;
    logic [SCNT_W-1:0] scnt_q;
    logic              bclk_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rate_q <= RATE_X1;
            scnt_q <= '0;
            bclk_q <= 1'b0;
        end else begin
            if (load_i) begin
                rate_q <= rate_e'(rate_i);
            end
            if (end_i) begin
                if (scnt_q >= toggle_limit(rate_q)) begin
                    scnt_q <= '0;
                    bclk_q <= ~bclk_q;
                end else begin
                    scnt_q <= scnt_q + SCNT_W'(1);
                end
            end
        end
    end

    assign bclk_o = bclk_q;

    AST_BCLK_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(bclk_q) |-> $past(end_i)); // R6

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frbg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [1:0]        rate_i,
    output logic              tick16_o,
    output logic              bclk_o
);

    logic load;
    logic period_end;
    logic carry;

    frbg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (load),
        .frac_i  (frac_i),
        .carry_o (carry)
    );

    frbg_period_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .div_i   (div_i),
        .carry_i (carry),
        .load_o  (load),
        .end_o   (period_end),
        .tick_o  (tick16_o)
    );

    frbg_bitclk u_bclk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .end_i  (period_end),
        .rate_i (rate_i),
        .bclk_o (bclk_o)
    );

    AST_TICK_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end |=> tick16_o); // R2

endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd9;
    logic [3:0]  cfg_frac = 4'd5;
    logic [1:0]  cfg_rate = 2'b00;
    logic        tick16_o;
    logic        bclk_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frac_baud_gen u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .div_i    (cfg_div),
        .frac_i   (cfg_frac),
        .rate_i   (cfg_rate),
        .tick16_o (tick16_o),
        .bclk_o   (bclk_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_rem, m_acc, m_sc, m_half;
    bit m_loaded, m_tick, m_bclk;

    function automatic int half_of(input logic [1:0] r);
        if (r == 2'b01) return 4;
        if (r == 2'b10) return 2;
        return 8;
    endfunction

    task automatic start_period();
        int d;
        int ext;
        d = (cfg_div == 0) ? 1 : int'(cfg_div);
        m_acc = m_acc + int'(cfg_frac);
        ext = (m_acc >= 16) ? 1 : 0;
        m_acc = m_acc % 16;
        m_rem = d + ext;
        m_half = half_of(cfg_rate);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_loaded = 0; m_tick = 0; m_bclk = 0; m_sc = 0; m_acc = 0; m_half = 8;
        end else if (!m_loaded) begin
            start_period();
            m_loaded = 1;
            m_tick = 0;
        end else begin
            m_rem--;
            if (m_rem == 0) begin
                m_tick = 1;
                m_sc++;
                if (m_sc >= m_half) begin
                    m_bclk = !m_bclk;
                    m_sc = 0;
                end
                start_period();
            end else begin
                m_tick = 0;
            end
        end
    end

    // monitor
    int gaps[$];
    int bgaps[$];
    int last_tick = 0;
    bit have_last = 0;
    int tick_cnt = 0;
    logic prev_bclk = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(tick16_o == m_tick, "R7 model strobe", int'(tick16_o), int'(m_tick));
            chk(bclk_o == m_bclk, "R6 model bit clock", int'(bclk_o), int'(m_bclk));
            if (tick16_o) begin
                if (have_last) gaps.push_back(cyc - last_tick);
                last_tick = cyc;
                have_last = 1;
                tick_cnt++;
            end
            if (bclk_o != prev_bclk) begin
                bgaps.push_back(tick_cnt);
                tick_cnt = 0;
            end
            prev_bclk = bclk_o;
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_gaps(input int n);
        while (gaps.size() < n) step();
    endtask

    task automatic wait_bgaps(input int n);
        while (bgaps.size() < n) step();
    endtask

    task automatic settle();
        gaps.delete();
        wait_gaps(2);
        gaps.delete();
        bgaps.delete();
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            step();
            chk(tick16_o == 1'b0, "R1 tick in reset", int'(tick16_o), 0);
            chk(bclk_o == 1'b0, "R1 bclk in reset", int'(bclk_o), 0);
        end
        rst_n = 1'b1;
        step();
        chk(tick16_o == 1'b0, "R1 tick after reset", int'(tick16_o), 0);
        chk(bclk_o == 1'b0, "R1 bclk after reset", int'(bclk_o), 0);

        // R7: stretch pattern from reset, DIV=9 FRACT=5; gaps[j] is period j+2
        wait_gaps(160);
        for (int j = 0; j < 16; j++) begin
            int k;
            int e;
            k = j + 2;
            e = 9 + ((((5 * k) / 16) != ((5 * (k - 1)) / 16)) ? 1 : 0);
            chk(gaps[j] == e, "R7 stretch pattern", gaps[j], e);
        end
        begin
            int sum;
            int bad;
            real baud;
            sum = 0;
            bad = 0;
            for (int j = 0; j < 160; j++) begin
                sum += gaps[j];
                if (gaps[j] != 9 && gaps[j] != 10) bad++;
            end
            chk(bad == 0, "R2 spacing 9 or 10", bad, 0);
            chk(sum >= 1489 && sum <= 1491, "R3 160-period total", sum, 1490);
            for (int s = 0; s + 16 <= 160; s += 16) begin
                int w;
                w = 0;
                for (int j = s; j < s + 16; j++) w += gaps[j];
                chk(w == 149, "R3 16-period window", w, 149);
            end
            baud = 28.23e6 * 160.0 / (16.0 * real'(sum));
            chk(baud > 189462.0 && baud < 189464.5, "R3 baud estimate", int'(baud), 189463);
        end

        // R2: integer-only divisor
        cfg_div = 16'd4; cfg_frac = 4'd0;
        settle();
        wait_gaps(20);
        begin
            int bad;
            bad = 0;
            for (int j = 0; j < 20; j++) if (gaps[j] != 4) bad++;
            chk(bad == 0, "R2 exact spacing DIV=4", bad, 0);
        end

        // R4: DIV=0 acts as 1
        cfg_div = 16'd0; cfg_frac = 4'd0;
        settle();
        for (int i = 0; i < 20; i++) begin
            step();
            chk(tick16_o == 1'b1, "R4 continuous strobe", int'(tick16_o), 1);
        end
        cfg_div = 16'd1; cfg_frac = 4'd8;
        settle();
        wait_gaps(16);
        begin
            int sum;
            sum = 0;
            for (int j = 0; j < 16; j++) sum += gaps[j];
            chk(sum == 24, "R4 DIV=1 FRACT=8 window", sum, 24);
        end

        // R5: mid-period change
        cfg_div = 16'd20; cfg_frac = 4'd0;
        settle();
        for (int i = 0; i < 5; i++) step();
        cfg_div = 16'd3;
        wait_gaps(3);
        chk(gaps[0] == 20, "R5 old period kept", gaps[0], 20);
        chk(gaps[1] == 3, "R5 new period", gaps[1], 3);
        chk(gaps[2] == 3, "R5 new period again", gaps[2], 3);

        // R6: bit clock per rate mode
        cfg_div = 16'd2; cfg_frac = 4'd0;
        for (int r = 0; r < 4; r++) begin
            int e;
            cfg_rate = 2'(r);
            e = (r == 1) ? 4 : (r == 2) ? 2 : 8;
            settle();
            wait_bgaps(4);
            chk(bgaps[2] == e, "R6 strobes per half bit", bgaps[2], e);
            chk(bgaps[3] == e, "R6 strobes per half bit", bgaps[3], e);
        end

        // R5 with stretch on the boundary where settings change
        cfg_div = 16'd3; cfg_frac = 4'd15; cfg_rate = 2'b10;
        settle();
        wait_gaps(1);
        gaps.delete();
        cfg_div = 16'd6; cfg_rate = 2'b00;
        wait_gaps(2);
        chk(gaps[0] == 3 || gaps[0] == 4, "R5 stretched old period", gaps[0], 4);
        chk(gaps[1] == 6 || gaps[1] == 7, "R5 period after change", gaps[1], 7);
        for (int i = 0; i < 200; i++) step();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule